// File: doc/BRIEF.md
# Split-Permission Translation Lookaside Buffer

This block is a direct-mapped cache of virtual-to-physical page translations. Every entry stores three separate tags, one each for loads, stores and instruction fetches, and one shared physical page number. A lookup compares only the tag that belongs to the requested access kind. A hit returns the translated address in the same cycle.

On a miss the block holds the virtual address and asks an external page-table walker for the page table entry. It stalls further lookups until the walker answers. When the entry arrives, the block picks the permission bits for the current privilege level. It then checks that the entry is valid and grants the permission the access needs.

- On success, the block writes each of the three tags only if its own permission is present, and sets the others to the all-ones invalid value.
- On failure, the block leaves the entry untouched. It pulses a fault of the matching type and latches the faulting virtual address.

A flush input clears every tag of every entry at once.

Top module: `splitPermTlb`

## Requirements
- R1: After reset every tag holds the invalid value, and `lookupHit`, `walkReq` and `faultValid` are 0.
- R2: The entry index is virtual address bits [17:12] (page shift 12, 64 entries), and the tag is bits [31:12]. A lookup hits only if the tag for the requested kind matches. Kind encoding: 0 load, 1 store, 2 fetch.
- R3: A valid lookup that misses while idle raises `walkReq` in the following cycle, with `walkAddr` equal to the missing virtual address. Both are held until `walkValid`. While the request is outstanding, `lookupStall` is 1 and `lookupHit` is 0.
- R4: Page table entry layout: bit 0 valid, bit 2 user read, bit 3 user write, bit 4 user execute, bits 7:5 the supervisor read/write/execute, bits 31:12 the physical page number. A successful refill writes the load, store and fetch tags each only if read, write and execute permission respectively is granted. Every other tag of that entry becomes invalid.
- R5: When `supervisor` is 1 at the time of the miss, the permission bits are taken from bits 7:5 instead of bits 4:2.
- R6: A refill faults when the valid bit or the permission the access needs (read for a load, write for a store, execute for a fetch) is missing. A faulting refill writes no tag.
- R7: A fault produces a one-cycle `faultValid` pulse in the cycle after the walker response. `faultKind` is the access kind (0 load, 1 store, 2 fetch fault), and `badAddr` holds the faulting virtual address.
- R8: On a hit, `lookupPaddr` is the stored physical page number in bits 31:12, followed by the virtual page offset bits 11:0.
- R9: `flush` invalidates every tag in one cycle. It takes priority over a refill write in the same cycle.
- R10: A hit is reported combinationally in the cycle the lookup is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | Lookup request present |
| lookupKind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| lookupVaddr | input | 32 | Virtual address to translate |
| supervisor | input | 1 | Current privilege is supervisor |
| flush | input | 1 | Invalidate every tag |
| lookupHit | output | 1 | Translation found for this kind |
| lookupPaddr | output | 32 | Translated physical address |
| lookupStall | output | 1 | Refill outstanding, lookups held |
| walkReq | output | 1 | Request to the page-table walker |
| walkAddr | output | 32 | Virtual address being walked |
| walkValid | input | 1 | Walker response present |
| walkPte | input | 32 | Page table entry from the walker |
| faultValid | output | 1 | Access fault pulse |
| faultKind | output | 2 | Fault type: 0 load, 1 store, 2 fetch |
| badAddr | output | 32 | Latched faulting virtual address |

## Verification
The bench targets page table entries that grant only some permissions. After each refill it probes all three kinds at the same address. A design that wrote all tags, or one that left a stale tag in place, would then report a hit for a kind that was never allowed. It also uses supervisor-only entries in both privilege modes, which exposes a missing or wrong shift as a fault in the wrong mode. It aliases several pages onto a few indices, so a refill must evict the previous tags. Finally, it raises flush in the same cycle as a successful walker response, where a design that lets the write win would hit afterwards.

// File: rtl/tlbPkg.sv
package tlbPkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } accKindT;

  typedef struct packed {
    logic startRefill;
    logic writeEntry;
    logic raiseFault;
    logic flushAll;
  } tlbStrobeT;
endpackage

// File: rtl/tlbCtrl.sv
module tlbCtrl
  import tlbPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      lookupValid,
  input  logic      rawHit,
  input  logic      flush,
  input  logic      walkValid,
  input  logic      permOk,
  output tlbStrobeT strobe,
  output logic      busy
);
  typedef enum logic {ST_IDLE, ST_WAIT} stateT;
  stateT state;

  always_comb begin
    strobe = '0;
    strobe.flushAll    = flush;
    strobe.startRefill = (state == ST_IDLE) && lookupValid && !rawHit && !flush;
    strobe.writeEntry  = (state == ST_WAIT) && walkValid && permOk;
    strobe.raiseFault  = (state == ST_WAIT) && walkValid && !permOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else if (strobe.startRefill) state <= ST_WAIT;
    else if (state == ST_WAIT && walkValid) state <= ST_IDLE;
  end

  assign busy = (state == ST_WAIT);

  AST_REQ_ONLY_AFTER_MISS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(lookupValid && !rawHit)); // R3
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.writeEntry, strobe.raiseFault, strobe.startRefill})); // R6
endmodule

// File: rtl/tlbDatapath.sv
module tlbDatapath
  import tlbPkg::*;
#(
  parameter int PAGE_SHIFT = 12,
  parameter int ENTRIES    = 64,
  parameter int VA_W       = 32,
  parameter int PA_W       = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  tlbStrobeT       strobe,
  input  logic [1:0]      lkKind,
  input  logic [VA_W-1:0] lkVaddr,
  input  logic            supervisor,
  input  logic [PA_W-1:0] walkPte,
  output logic            rawHit,
  output logic [PA_W-1:0] lkPaddr,
  output logic            permOk,
  output logic [VA_W-1:0] walkAddr,
  output logic            faultValid,
  output logic [1:0]      faultKind,
  output logic [VA_W-1:0] badAddr
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int TAG_W  = VA_W - PAGE_SHIFT;
  localparam int PPN_W  = PA_W - PAGE_SHIFT;
  localparam int KINDS  = 3;
  localparam int UPERM  = 2;
  localparam int SPERM  = UPERM + 3;

  logic [VA_W-1:0]  reqVaddr;
  logic [1:0]       reqKind;
  logic             reqSup;
  logic [PPN_W-1:0] ppnMem [ENTRIES];
  logic [KINDS-1:0] kindHit;
  logic [KINDS-1:0] grant;

  wire [IDX_W-1:0] lkIdx  = lkVaddr[PAGE_SHIFT +: IDX_W];
  wire [TAG_W-1:0] lkTag  = lkVaddr[VA_W-1:PAGE_SHIFT];
  wire [IDX_W-1:0] refIdx = reqVaddr[PAGE_SHIFT +: IDX_W];
  wire [TAG_W-1:0] refTag = reqVaddr[VA_W-1:PAGE_SHIFT];
  wire [1:0] lkSel  = (lkKind == 2'd3) ? 2'd0 : lkKind;
  wire [1:0] reqSel = (reqKind == 2'd3) ? 2'd0 : reqKind;

  logic unusedPte;
  assign unusedPte = ^{walkPte[PAGE_SHIFT-1:SPERM+3], walkPte[1]};

  // supervisor bits slide down into the user read/write/execute slots
  assign grant  = reqSup ? walkPte[SPERM +: KINDS] : walkPte[UPERM +: KINDS];
  assign permOk = walkPte[0] && grant[reqSel];

  for (genvar k = 0; k < KINDS; k++) begin : gKind
    logic [TAG_W-1:0] tags [ENTRIES];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < ENTRIES; i++) tags[i] <= '1;
      end else if (strobe.flushAll) begin
        for (int i = 0; i < ENTRIES; i++) tags[i] <= '1;
      end else if (strobe.writeEntry) begin
        tags[refIdx] <= grant[k] ? refTag : '1;
      end
    end
    assign kindHit[k] = (tags[lkIdx] == lkTag);
  end

  always_ff @(posedge clk) begin
    if (strobe.writeEntry && !strobe.flushAll)
      ppnMem[refIdx] <= walkPte[PA_W-1:PAGE_SHIFT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqVaddr   <= '0;
      reqKind    <= '0;
      reqSup     <= 1'b0;
      badAddr    <= '0;
      faultKind  <= '0;
      faultValid <= 1'b0;
    end else begin
      faultValid <= strobe.raiseFault;
      if (strobe.startRefill) begin
        reqVaddr <= lkVaddr;
        reqKind  <= lkKind;
        reqSup   <= supervisor;
      end
      if (strobe.raiseFault) begin
        badAddr   <= reqVaddr;
        faultKind <= reqSel;
      end
    end
  end

  assign rawHit   = kindHit[lkSel];
  assign lkPaddr  = {ppnMem[lkIdx], lkVaddr[PAGE_SHIFT-1:0]};
  assign walkAddr = reqVaddr;

  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |=> !faultValid); // R7
  AST_FAULT_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> faultKind != 2'd3); // R7
endmodule

// File: rtl/splitPermTlb.sv
module splitPermTlb
  import tlbPkg::*;
#(
  parameter int PAGE_SHIFT = 12,
  parameter int ENTRIES    = 64,
  parameter int VA_W       = 32,
  parameter int PA_W       = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            lookupValid,
  input  logic [1:0]      lookupKind,
  input  logic [VA_W-1:0] lookupVaddr,
  input  logic            supervisor,
  input  logic            flush,
  output logic            lookupHit,
  output logic [PA_W-1:0] lookupPaddr,
  output logic            lookupStall,
  output logic            walkReq,
  output logic [VA_W-1:0] walkAddr,
  input  logic            walkValid,
  input  logic [PA_W-1:0] walkPte,
  output logic            faultValid,
  output logic [1:0]      faultKind,
  output logic [VA_W-1:0] badAddr
);
  tlbStrobeT strobe;
  logic rawHit, permOk, busy;

  tlbCtrl uCtrl (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .rawHit(rawHit),
    .flush(flush), .walkValid(walkValid), .permOk(permOk),
    .strobe(strobe), .busy(busy)
  );

  tlbDatapath #(
    .PAGE_SHIFT(PAGE_SHIFT), .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lkKind(lookupKind),
    .lkVaddr(lookupVaddr), .supervisor(supervisor), .walkPte(walkPte),
    .rawHit(rawHit), .lkPaddr(lookupPaddr), .permOk(permOk),
    .walkAddr(walkAddr), .faultValid(faultValid), .faultKind(faultKind),
    .badAddr(badAddr)
  );

  assign lookupHit   = lookupValid && !busy && rawHit;
  assign lookupStall = busy;
  assign walkReq     = busy;

  AST_WALK_HELD: assert property (@(posedge clk) disable iff (!rstN)
    walkReq && !walkValid |=> walkReq && $stable(walkAddr)); // R3
  AST_BADADDR_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> badAddr == $past(walkAddr)); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !(lookupHit && lookupVaddr[VA_W-1:PAGE_SHIFT] != '1)); // R9
  AST_NO_FAULT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> !lookupHit || $past(!lookupValid)); // R6
endmodule

// File: tb/splitPermTlb_test.sv
`timescale 1ns/1ps
module splitPermTlb_test;
  logic clk = 0, rstN = 0;
  logic lookupValid = 0, supervisor = 0, flush = 0, walkValid = 0;
  logic [1:0] lookupKind = 0;
  logic [31:0] lookupVaddr = 0, walkPte = 0;
  logic lookupHit, lookupStall, walkReq, faultValid;
  logic [31:0] lookupPaddr, walkAddr, badAddr;
  logic [1:0] faultKind;

  int checks = 0, fails = 0;
  logic [19:0] mTag [3][64];
  logic [19:0] mPpn [64];

  always #10 clk = ~clk;

  splitPermTlb uut (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupKind(lookupKind),
    .lookupVaddr(lookupVaddr), .supervisor(supervisor), .flush(flush),
    .lookupHit(lookupHit), .lookupPaddr(lookupPaddr), .lookupStall(lookupStall),
    .walkReq(walkReq), .walkAddr(walkAddr), .walkValid(walkValid), .walkPte(walkPte),
    .faultValid(faultValid), .faultKind(faultKind), .badAddr(badAddr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] effPerm(input logic [31:0] pte, input bit sup);
    return sup ? pte[7:5] : pte[4:2];
  endfunction

  function automatic bit expHit(input int k, input logic [31:0] va);
    return mTag[k][va[17:12]] == va[31:12];
  endfunction

  task automatic clearModel();
    for (int k = 0; k < 3; k++) for (int i = 0; i < 64; i++) mTag[k][i] = '1;
  endtask

  // probe every kind at va; lookup presented at a negedge, sampled after settling
  task automatic probeAll(input logic [31:0] va, input string req);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      lookupValid = 1; lookupKind = k[1:0]; lookupVaddr = va;
      #1;
      check(lookupHit == expHit(k, va), req, {31'b0, lookupHit}, {31'b0, expHit(k, va)});
      if (expHit(k, va))
        check(lookupPaddr == {mPpn[va[17:12]], va[11:0]}, "R8", lookupPaddr, {mPpn[va[17:12]], va[11:0]});
      @(negedge clk);
      lookupValid = 0;
      if (!expHit(k, va)) begin
        // a miss starts a refill; answer it with a non-valid entry to keep model intact
        walkValid = 1; walkPte = 32'h0;
        @(negedge clk);
        walkValid = 0;
      end
    end
  endtask

  task automatic access(input int k, input logic [31:0] va, input bit sup,
                        input logic [31:0] pte, input bit flushResp);
    bit hit, fault;
    logic [2:0] p;
    @(negedge clk);
    lookupValid = 1; lookupKind = k[1:0]; lookupVaddr = va; supervisor = sup;
    #1;
    hit = expHit(k, va);
    check(lookupHit == hit, "R2 R10 hit", {31'b0, lookupHit}, {31'b0, hit});
    if (hit) begin
      check(lookupPaddr == {mPpn[va[17:12]], va[11:0]}, "R8 paddr", lookupPaddr, {mPpn[va[17:12]], va[11:0]});
      @(negedge clk);
      lookupValid = 0;
      return;
    end
    @(negedge clk);
    check(walkReq == 1'b1 && walkAddr == va, "R3 walk request", walkAddr, va);
    #1;
    check(lookupStall == 1'b1 && lookupHit == 1'b0, "R3 stall", {30'b0, lookupStall, lookupHit}, 32'h2);
    lookupValid = 0;
    walkValid = 1; walkPte = pte; flush = flushResp;
    @(negedge clk);
    walkValid = 0; flush = 0;
    p = effPerm(pte, sup);
    fault = !(pte[0] && p[k]);
    check(faultValid == fault, "R6 fault", {31'b0, faultValid}, {31'b0, fault});
    check(walkReq == 1'b0, "R3 request drops", {31'b0, walkReq}, 32'h0);
    if (fault) begin
      check(faultKind == k[1:0] && badAddr == va, "R7 fault info", badAddr, va);
    end
    if (flushResp) clearModel();
    else if (!fault) begin
      for (int j = 0; j < 3; j++) mTag[j][va[17:12]] = p[j] ? va[31:12] : '1;
      mPpn[va[17:12]] = pte[31:12];
    end
    @(negedge clk);
    check(faultValid == 1'b0, "R7 pulse", {31'b0, faultValid}, 32'h0);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_7a1b));
    clearModel();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    check(walkReq == 0 && faultValid == 0 && lookupStall == 0, "R1 reset outputs",
          {29'b0, walkReq, faultValid, lookupStall}, 32'h0);
    probeAll(32'h0000_3123, "R1 empty after reset");

    // R4: read-only entry grants load only
    access(0, 32'h0001_2abc, 0, 32'h000a_b005, 0);
    probeAll(32'h0001_2abc, "R4 partial grant");
    // R5: supervisor-only execute in supervisor mode succeeds
    access(2, 32'h0002_5010, 1, 32'h0012_3081, 0);
    probeAll(32'h0002_5010, "R5 supervisor shift");
    // R5/R6: same kind of entry in user mode faults
    access(2, 32'h0003_6020, 0, 32'h0012_3081, 0);
    // R6: valid bit clear faults a store
    access(1, 32'h0004_7030, 0, 32'h0055_501c, 0);
    probeAll(32'h0004_7030, "R6 no write on fault");
    // R2: alias at same index evicts
    access(0, 32'h0041_2000, 0, 32'h0077_701d, 0);
    probeAll(32'h0001_2abc, "R2 eviction");
    // R9: flush concurrent with successful response
    access(1, 32'h0005_8040, 0, 32'h0099_901d, 1);
    probeAll(32'h0041_2000, "R9 flush with write");
    // R9: standalone flush
    access(0, 32'h0006_9000, 0, 32'h0011_101d, 0);
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0; clearModel();
    probeAll(32'h0006_9000, "R9 flush");

    for (int n = 0; n < 400; n++) begin
      int k, idx, hi;
      logic [31:0] va, pte;
      k = $urandom % 3;
      idx = $urandom % 8;
      hi = $urandom % 3;
      va = (hi << 18) | (idx << 12) | ($urandom % 4096);
      pte = {$urandom % 32'h100000, 12'h0} & 32'hffff_f000;
      pte[7:2] = $urandom % 64;
      pte[0] = ($urandom % 8) != 0;
      access(k, va, ($urandom % 2) == 1, pte, ($urandom % 40) == 0);
      if (n % 10 == 0) probeAll(va, "R4 R5 random probe");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule